// File: doc/BRIEF.md
# Stop Mode Wakeup Controller

This block sequences a small microcontroller into and out of its low-power stop state. The CPU requests stop by pulsing a request input. While the block is stopped, the oscillator is disabled and internal operation is stalled. Two kinds of event can wake it.

The first is a key pin whose active level is programmable. The second is one of two supply-voltage comparators. Each comparator has its own mode bit that picks one of two release styles:

- **Reset style.** The block raises a system reset request while the supply is low. It starts warm-up once the supply recovers.
- **Interrupt style.** The block releases stop when the supply rises back to the threshold.

On release, the oscillator is re-enabled and a programmable warm-up count runs down on oscillator ticks while the CPU stays stalled. The block then resumes normal operation. At that point it pulses a clear to the prescaler and the timing divider and sets a done flag. All asynchronous inputs pass through two-flop synchronizers. A source is evaluated two clock edges after its pin changes, so the state changes on the third edge.

Top module: `stop_wake_ctrl`

## Requirements
- R1: After reset the block is running: osc_en=1, cpu_stall=0, sys_rst_req=0, div_clr=0, wake_done=0, stop_req=0.
- R2: A stop_set pulse while running makes stop_req=1, osc_en=0 and cpu_stall=1 from the next cycle and clears wake_done. A stop_set pulse in any other state is ignored.
- R3: While stopped, the synchronized key pin equal to key_hi releases stop. key_hi=1 means high releases and key_hi=0 means low releases. The release starts warm-up with osc_en=1, cpu_stall=1 and stop_req=0, visible after the third clock edge following the pin change.
- R4: vd_sel=01 enables wakeup from comparator 0 only, vd_sel=10 from comparator 1 only, and 00 or 11 disables comparator wakeup. A non-selected comparator has no effect.
- R5: For the selected comparator with vd_rst_mode bit 1, vd_ok=0 while stopped moves the block to reset hold: sys_rst_req=1, osc_en=0, cpu_stall=1, stop_req=0. When vd_ok returns to 1, the reset request drops and warm-up begins.
- R6: For the selected comparator with vd_rst_mode bit 0, a 0-to-1 transition of the synchronized vd_ok while stopped releases stop into warm-up. A level that is already high does not.
- R7: A vd_ok rising transition in interrupt style that reaches the synchronized domain during the first stopped cycle does not release stop.
- R8: Warm-up lasts exactly max(warm_cnt,1) cycles in which osc_tick is 1. Cycles without a tick do not advance it.
- R9: At the end of warm-up, cpu_stall falls, div_clr pulses for exactly one cycle and wake_done is set. wake_done stays set until the next stop entry.
- R10: Once warm-up has started, the key pin returning to its inactive level does not put the block back into stop.
- R11: When a reset-style comparator event and a key release arrive in the same cycle, the block enters reset hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_set | input | 1 | CPU request to enter stop |
| key_pin | input | 1 | Raw key wakeup pin |
| key_hi | input | 1 | Release level of the key pin (1 high, 0 low) |
| vd_ok | input | 2 | Comparator outputs, 1 = supply at or above threshold |
| vd_rst_mode | input | 2 | Per-comparator style, 1 reset, 0 interrupt |
| vd_sel | input | 2 | Comparator wakeup select (01 comp 0, 10 comp 1) |
| warm_cnt | input | CNT_W | Warm-up length in oscillator ticks |
| osc_tick | input | 1 | Oscillator tick enable for warm-up counting |
| osc_en | output | 1 | Oscillator enable |
| cpu_stall | output | 1 | Holds internal operation |
| sys_rst_req | output | 1 | System reset request |
| div_clr | output | 1 | One-cycle clear of prescaler and divider |
| wake_done | output | 1 | Set on return to normal operation |
| stop_req | output | 1 | Stop request bit, cleared on leaving stop |

## Verification
The hardest situation to reach is the one-cycle entry guard. A comparator rising transition must arrive through the synchronizer in exactly the first stopped cycle. The bench raises the raw comparator one clock edge before the edge that accepts stop_set, which places the synchronized transition inside the guard, and expects no release. It then repeats the sequence with the rise on the same edge as stop_set and expects a release. Warm-up length is swept over a range of counts with both dense and sparse tick patterns, and the bench counts the ticks it actually supplied.

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_set,
  input  logic             key_pin,
  input  logic             key_hi,
  input  logic [1:0]       vd_ok,
  input  logic [1:0]       vd_rst_mode,
  input  logic [1:0]       vd_sel,
  input  logic [CNT_W-1:0] warm_cnt,
  input  logic             osc_tick,
  output logic             osc_en,
  output logic             cpu_stall,
  output logic             sys_rst_req,
  output logic             div_clr,
  output logic             wake_done,
  output logic             stop_req
);

  typedef enum logic [1:0] {RUN, STOP, WARMUP, RESET_HOLD} st_t;

  st_t             state;
  logic [CNT_W-1:0] cnt;
  logic            fresh;
  logic            key_f1, key_s;
  logic [1:0]      vd_f1, vd_s, vd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_f1 <= 1'b0;
      key_s  <= 1'b0;
      vd_f1  <= '0;
      vd_s   <= '0;
      vd_q   <= '0;
    end else begin
      key_f1 <= key_pin;
      key_s  <= key_f1;
      vd_f1  <= vd_ok;
      vd_s   <= vd_f1;
      vd_q   <= vd_s;
    end
  end

  logic vd_en, idx, det_lvl, det_prev, rmode;
  logic rst_wake, int_wake, key_wake;

  assign vd_en    = vd_sel[0] ^ vd_sel[1];
  assign idx      = vd_sel[1];
  assign det_lvl  = vd_s[idx];
  assign det_prev = vd_q[idx];
  assign rmode    = vd_rst_mode[idx];
  assign rst_wake = vd_en & rmode & ~det_lvl;
  assign int_wake = vd_en & ~rmode & det_lvl & ~det_prev & ~fresh;
  assign key_wake = (key_s == key_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RUN;
      cnt       <= '0;
      fresh     <= 1'b0;
      div_clr   <= 1'b0;
      wake_done <= 1'b0;
      stop_req  <= 1'b0;
    end else begin
      div_clr <= 1'b0;
      fresh   <= 1'b0;
      case (state)
        RUN: if (stop_set) begin
          state     <= STOP;
          stop_req  <= 1'b1;
          fresh     <= 1'b1;
          wake_done <= 1'b0;
        end
        STOP: if (rst_wake) begin
          state    <= RESET_HOLD;
          stop_req <= 1'b0;
        end else if (key_wake || int_wake) begin
          state    <= WARMUP;
          cnt      <= warm_cnt;
          stop_req <= 1'b0;
        end
        RESET_HOLD: if (!rst_wake) begin
          state <= WARMUP;
          cnt   <= warm_cnt;
        end
        WARMUP: if (osc_tick) begin
          if (cnt <= 1) begin
            state     <= RUN;
            cnt       <= '0;
            div_clr   <= 1'b1;
            wake_done <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= RUN;
      endcase
    end
  end

  assign osc_en      = (state == RUN) || (state == WARMUP);
  assign cpu_stall   = (state != RUN);
  assign sys_rst_req = (state == RESET_HOLD);

endmodule

// File: rtl/stop_wake_ctrl_chk.sv
module stop_wake_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic stop_set,
  input logic osc_tick,
  input logic osc_en,
  input logic cpu_stall,
  input logic sys_rst_req,
  input logic div_clr,
  input logic wake_done,
  input logic stop_req
);

  AST_STALL_WHEN_OSC_OFF: assert property (@(posedge clk) disable iff (!rst_n) !osc_en |-> cpu_stall); // R2
  AST_STOP_REQ_STOPPED: assert property (@(posedge clk) disable iff (!rst_n) stop_req |-> (!osc_en && !sys_rst_req)); // R2
  AST_STOP_ENTRY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(stop_req) |-> $past(stop_set)); // R2
  AST_RESET_HOLD_SHAPE: assert property (@(posedge clk) disable iff (!rst_n) sys_rst_req |-> (!osc_en && cpu_stall && !stop_req)); // R5
  AST_WARM_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n) (osc_en && cpu_stall && !osc_tick) |=> cpu_stall); // R8
  AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) div_clr |=> !div_clr); // R9
  AST_CLR_ON_RESUME: assert property (@(posedge clk) disable iff (!rst_n) div_clr |-> (wake_done && !cpu_stall && $past(cpu_stall))); // R9
  AST_NO_RESTOP: assert property (@(posedge clk) disable iff (!rst_n) (osc_en && cpu_stall) |=> osc_en); // R10

endmodule

bind stop_wake_ctrl stop_wake_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stop_set(stop_set), .osc_tick(osc_tick),
  .osc_en(osc_en), .cpu_stall(cpu_stall), .sys_rst_req(sys_rst_req),
  .div_clr(div_clr), .wake_done(wake_done), .stop_req(stop_req)
);

// File: tb/stop_wake_ctrl_bench.sv
module stop_wake_ctrl_bench;
  localparam int CNT_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic stop_set = 0, key_pin = 0, key_hi = 1, osc_tick = 0;
  logic [1:0] vd_ok = 2'b11, vd_rst_mode = 2'b00, vd_sel = 2'b00;
  logic [CNT_W-1:0] warm_cnt = '0;
  logic osc_en, cpu_stall, sys_rst_req, div_clr, wake_done, stop_req;
  int total = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  stop_wake_ctrl #(.CNT_W(CNT_W)) u_stop_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .stop_set(stop_set), .key_pin(key_pin), .key_hi(key_hi),
    .vd_ok(vd_ok), .vd_rst_mode(vd_rst_mode), .vd_sel(vd_sel), .warm_cnt(warm_cnt),
    .osc_tick(osc_tick), .osc_en(osc_en), .cpu_stall(cpu_stall), .sys_rst_req(sys_rst_req),
    .div_clr(div_clr), .wake_done(wake_done), .stop_req(stop_req)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic enter_stop();
    stop_set = 1; cyc(1); stop_set = 0;
    chk("R2 stop_req", stop_req, 1);
    chk("R2 osc_en", osc_en, 0);
    chk("R2 wake_done cleared", wake_done, 0);
  endtask

  task automatic key_wake();
    key_pin = key_hi; cyc(2);
    chk("R3 latency", osc_en, 0);
    cyc(1);
    chk("R3 osc_en", osc_en, 1);
    chk("R3 stall", cpu_stall, 1);
    chk("R3 stop_req", stop_req, 0);
  endtask

  task automatic finish_warm(input int n, input int per);
    int ticks = 0;
    int c = 0;
    bit tk;
    while (osc_en && cpu_stall && c < 3000) begin
      tk = (c % per) == 0;
      osc_tick = tk;
      if (tk) ticks++;
      c++;
      cyc(1);
    end
    osc_tick = 0;
    chk("R8 ticks", ticks, (n < 1) ? 1 : n);
    chk("R9 div_clr", div_clr, 1);
    chk("R9 wake_done", wake_done, 1);
    chk("R9 stall", cpu_stall, 0);
    cyc(1);
    chk("R9 div_clr single", div_clr, 0);
    chk("R9 wake_done held", wake_done, 1);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      fails++; total++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    cyc(3); rst_n = 1; cyc(1);
    chk("R1 osc_en", osc_en, 1);
    chk("R1 stall", cpu_stall, 0);
    chk("R1 rst", sys_rst_req, 0);
    chk("R1 div_clr", div_clr, 0);
    chk("R1 done", wake_done, 0);
    chk("R1 stop_req", stop_req, 0);

    // R2, R4: disabled detector selects, reset style
    key_hi = 1; key_pin = 0; vd_rst_mode = 2'b11; warm_cnt = 8'd10;
    enter_stop();
    foreach (vd_sel[i]) ;
    vd_sel = 2'b00; vd_ok = 2'b00; cyc(5);
    chk("R4 sel00 ignored", sys_rst_req, 0);
    vd_sel = 2'b11; cyc(5);
    chk("R4 sel11 ignored", sys_rst_req, 0);
    chk("R2 still stopped", stop_req, 1);
    vd_sel = 2'b00; vd_ok = 2'b11;
    key_wake();
    // R10: key back to inactive during warm-up
    key_pin = 0; cyc(6);
    chk("R10 osc stays on", osc_en, 1);
    chk("R10 still warming", cpu_stall, 1);
    stop_set = 1; cyc(1); stop_set = 0; cyc(1);
    chk("R2 stop_set ignored in warmup", stop_req, 0);
    finish_warm(10, 1);

    // R3: low active level
    key_hi = 0; key_pin = 1; cyc(3);
    enter_stop(); cyc(3);
    chk("R3 inactive high holds stop", osc_en, 0);
    key_wake();
    finish_warm(10, 1);
    key_hi = 1; key_pin = 0; cyc(3);

    // R8 sweep with dense and sparse ticks
    for (int per = 1; per <= 3; per += 2) begin
      for (int n = 0; n <= 15; n++) begin
        warm_cnt = n[CNT_W-1:0];
        enter_stop(); cyc(1);
        key_wake();
        key_pin = 0;
        finish_warm(n, per);
        cyc(2);
      end
    end

    // R4, R5: reset style per selected comparator
    warm_cnt = 8'd3;
    for (int s = 0; s < 2; s++) begin
      vd_sel = (s == 0) ? 2'b01 : 2'b10;
      vd_rst_mode = 2'b11; vd_ok = 2'b11; cyc(4);
      enter_stop();
      vd_ok[1-s] = 0; cyc(5);
      chk("R4 other comp ignored", stop_req, 1);
      chk("R4 other comp no rst", sys_rst_req, 0);
      vd_ok[s] = 0; cyc(3);
      chk("R5 rst_req", sys_rst_req, 1);
      chk("R5 osc off", osc_en, 0);
      chk("R5 stop_req cleared", stop_req, 0);
      cyc(4);
      chk("R5 hold while low", sys_rst_req, 1);
      vd_ok = 2'b11; cyc(2);
      chk("R5 hold latency", sys_rst_req, 1);
      cyc(1);
      chk("R5 rst released", sys_rst_req, 0);
      chk("R5 warm-up", osc_en & cpu_stall, 1);
      finish_warm(3, 1);
    end

    // R6: interrupt style edge release
    vd_rst_mode = 2'b00;
    for (int s = 0; s < 2; s++) begin
      vd_sel = (s == 0) ? 2'b01 : 2'b10;
      vd_ok = 2'b11; cyc(4);
      enter_stop(); cyc(4);
      chk("R6 high level no release", stop_req, 1);
      vd_ok = 2'b00; cyc(4);
      vd_ok[1-s] = 1; cyc(5);
      chk("R6 other comp ignored", stop_req, 1);
      vd_ok[s] = 1; cyc(2);
      chk("R6 latency", osc_en, 0);
      cyc(1);
      chk("R6 released", osc_en, 1);
      finish_warm(3, 1);
    end

    // R7: rise reaching the synchronizer in the first stopped cycle
    vd_sel = 2'b01; vd_ok = 2'b00; cyc(4);
    vd_ok[0] = 1; cyc(1);
    stop_set = 1; cyc(1); stop_set = 0;
    chk("R7 entered", stop_req, 1);
    cyc(8);
    chk("R7 guarded edge no release", stop_req, 1);
    chk("R7 osc off", osc_en, 0);
    key_wake(); key_pin = 0;
    finish_warm(3, 1);
    vd_ok = 2'b00; cyc(4);
    vd_ok[0] = 1; stop_set = 1; cyc(1); stop_set = 0;
    cyc(4);
    chk("R7 edge one cycle later releases", osc_en, 1);
    finish_warm(3, 1);

    // R11: reset style beats key in the same cycle
    vd_sel = 2'b01; vd_rst_mode = 2'b01; vd_ok = 2'b11; cyc(4);
    enter_stop();
    key_pin = 1; vd_ok[0] = 0; cyc(3);
    chk("R11 reset wins", sys_rst_req, 1);
    chk("R11 osc off", osc_en, 0);
    vd_ok = 2'b11; cyc(3);
    chk("R11 warm after reset", sys_rst_req, 0);
    finish_warm(3, 1);

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule